// File: doc/BRIEF.md
# Serial EEPROM Word Master

This block drives a small serial EEPROM that stores 16-bit words. The bus has four wires: chip select, serial clock, master data out and device data in. The host starts one burst by giving a direction, a start address and a word count. A read burst returns each word on `rdata_o` with a one-cycle `rvalid_o` strobe. A write burst pulls each word through a `wvalid_i`/`wready_o` handshake.

The block builds every command frame and paces the serial clock from the system clock. The high and low times are parameters counted in system cycles. Chip select is released between frames. A write burst opens with a program-enable command and closes with a program-disable command. After each written word the block polls the device until the device reports that its internal programming cycle has finished. A poll limit stops a device that never becomes ready: the burst ends early with an error flag.

Top module: `eeprom_serial_master`

## Requirements
- R1: Every frame starts with a 1 bit, then a 2-bit opcode, then `ADDR_W` address bits sent MSB first.
  - The opcodes are: read `10`, write `01`, control `00`.
  - A control frame carries `11` in its two top address bits to enable programming, or `00` to disable it. All its other address bits are 0.
  - No erase opcode (`11`) and no other control code is ever sent.
- R2: A read frame is followed by 17 further serial clocks with `do_o` low. The first bit sampled is discarded. The remaining 16 bits form the word, MSB first. The word appears on `rdata_o` with `rvalid_o` high for one cycle.
- R3: A write frame carries the address and then the 16 data bits, MSB first. The 16 data bits come from the word accepted in the cycle where `wvalid_i` and `wready_o` are both high. Exactly one word is accepted per write frame.
- R4: Every write burst sends the enable control frame before its first write frame. It sends the disable control frame after its last word.
- R5: After each write frame, chip select drops and then rises again. Serial clocks then run with `do_o` low until a sampled `di_i` of 1 is seen. Only after that is the next word requested.
- R6: A burst covers addresses start through start+count−1 in increasing order, one frame per word. A count of 0 pulses `done_o` without raising chip select.
- R7: Chip select stays low for at least `CS_GAP_CYC` cycles between frames. `sclk_o` is high only while `cs_o` is high.
- R8: Timing of the serial clock:
  - Each `sclk_o` high phase lasts exactly `HIGH_CYC` cycles. Each low phase inside a frame lasts at least `LOW_CYC` cycles.
  - `do_o` does not change while `sclk_o` is high.
  - `di_i` is sampled in the last high cycle, and `sclk_o` falls together with the bit-complete pulse.
- R9: If `POLL_MAX` poll bits pass without a ready bit, the burst stops taking words and still sends the disable frame. It then pulses `done_o` with `err_o` high. `err_o` holds until the next accepted start. It is raised only for write bursts.
- R10: During and directly after reset, all of these are 0: `cs_o`, `sclk_o`, `do_o`, `busy_o`, `done_o`, `err_o`, `wready_o` and `rvalid_o`.
- R11: `start_i` is ignored while `busy_o` is high. The running burst keeps its direction, address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst (taken only when idle) |
| op_write_i | input | 1 | Burst direction: 1 write, 0 read |
| addr_i | input | ADDR_W | First word address |
| count_i | input | ADDR_W+1 | Number of words |
| wdata_i | input | 16 | Word to program |
| wvalid_i | input | 1 | Write word available |
| wready_o | output | 1 | Write word accepted this cycle when valid |
| rdata_o | output | 16 | Word read from the device |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at burst end |
| err_o | output | 1 | Last write burst hit the poll limit |
| cs_o | output | 1 | Device chip select |
| sclk_o | output | 1 | Serial clock |
| do_o | output | 1 | Serial data toward the device |
| di_i | input | 1 | Serial data from the device |

## Verification
Embedded assertions cover the rules that hold on every cycle:
- the serial clock runs only under chip select;
- outgoing data is stable while the clock is high;
- the clock falls together with the bit-complete pulse;
- frame loads never collide with shifts;
- read strobes occur only in read bursts, and errors only in write bursts;
- the write handshake never overlaps an active frame.

Some behaviour only the bench scenarios can show, using a behavioural device model:
- that the bit streams form correct frames, and the dummy bit is dropped;
- that addresses advance across a burst;
- that each write burst is bracketed by enable and disable;
- that the chip-select gaps and clock phase lengths meet their minimums;
- that a device which never becomes ready produces the error path with a clean disable.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int WORD_W = 16;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_CTRL  = 2'b00;
  localparam logic [1:0] CTRL_EN   = 2'b11;
  localparam logic [1:0] CTRL_DIS  = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FRAME, ST_RDIN, ST_WGET, ST_GAP, ST_POLL, ST_DONE
  } ee_state_e;

  typedef enum logic [2:0] {
    NX_WGET, NX_POLL, NX_READ, NX_EWDS, NX_DONE
  } ee_next_e;
endpackage

// File: rtl/ee_bit_engine.sv
module ee_bit_engine #(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic di_i,
  output logic idle_o,
  output logic sclk_o,
  output logic done_o,
  output logic bit_o
);
  localparam int PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic            active_q, hi_q, done_q, bit_q;
  logic [PH_W-1:0] cnt_q;

  assign idle_o = !active_q && !done_q;
  assign sclk_o = hi_q;
  assign done_o = done_q;
  assign bit_o  = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (req_i && idle_o) begin
          active_q <= 1'b1;
          cnt_q    <= PH_W'(LOW_CYC - 1);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - PH_W'(1);
      end else if (!hi_q) begin
        hi_q  <= 1'b1;
        cnt_q <= PH_W'(HIGH_CYC - 1);
      end else begin
        // sample at the end of the high phase, then fall
        active_q <= 1'b0;
        hi_q     <= 1'b0;
        done_q   <= 1'b1;
        bit_q    <= di_i;
      end
    end
  end

  // R8
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> done_o);
endmodule

// File: rtl/ee_frame_shift.sv
module ee_frame_shift #(
  parameter int W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  assign msb_o = sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  // R1
  load_shift_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/eeprom_serial_master.sv
module eeprom_serial_master
  import ee_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LOW_CYC    = 2,
  parameter int HIGH_CYC   = 3,
  parameter int CS_GAP_CYC = 4,
  parameter int POLL_MAX   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W:0]   count_i,
  input  logic [15:0]       wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int CNT_W   = ADDR_W + 1;
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + WORD_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int GAP_W   = $clog2(CS_GAP_CYC + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam logic [ADDR_W-1:0] A_EN  = {CTRL_EN,  {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] A_DIS = {CTRL_DIS, {(ADDR_W-2){1'b0}}};

  ee_state_e           state_q;
  ee_next_e            nxt_q;
  logic                rd_frame_q, op_wr_q, rvalid_q, done_q, err_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    left_q;
  logic [BIT_W-1:0]    bits_q;
  logic [GAP_W-1:0]    gap_q;
  logic [POLL_W-1:0]   poll_q;
  logic [WORD_W-1:0]   cap_q, rdata_q;

  logic                eng_req, eng_idle, eng_done, eng_bit;
  logic                ld_en, sh_en;
  logic [FRAME_W-1:0]  ld_val;

  function automatic logic [FRAME_W-1:0] mk_frame(logic [1:0] opc, logic [ADDR_W-1:0] a,
                                                  logic [WORD_W-1:0] d);
    return {1'b1, opc, a, d};
  endfunction

  assign cs_o     = (state_q == ST_FRAME) || (state_q == ST_RDIN) || (state_q == ST_POLL);
  assign busy_o   = (state_q != ST_IDLE);
  assign wready_o = (state_q == ST_WGET);
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign eng_req  = cs_o && eng_idle;
  assign sh_en    = (state_q == ST_FRAME) && eng_done;

  always_comb begin
    ld_en  = 1'b0;
    ld_val = '0;
    unique case (state_q)
      ST_IDLE: if (start_i && count_i != '0) begin
        ld_en  = 1'b1;
        ld_val = op_write_i ? mk_frame(OPC_CTRL, A_EN, '0) : mk_frame(OPC_READ, addr_i, '0);
      end
      ST_GAP: if (gap_q == '0) begin
        if (nxt_q == NX_READ) begin
          ld_en  = 1'b1;
          ld_val = mk_frame(OPC_READ, addr_q, '0);
        end else if (nxt_q == NX_EWDS) begin
          ld_en  = 1'b1;
          ld_val = mk_frame(OPC_CTRL, A_DIS, '0);
        end
      end
      ST_WGET: if (wvalid_i) begin
        ld_en  = 1'b1;
        ld_val = mk_frame(OPC_WRITE, addr_q, wdata_i);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nxt_q      <= NX_DONE;
      rd_frame_q <= 1'b0;
      op_wr_q    <= 1'b0;
      rvalid_q   <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      left_q     <= '0;
      bits_q     <= '0;
      gap_q      <= '0;
      poll_q     <= '0;
      cap_q      <= '0;
      rdata_q    <= '0;
    end else begin
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_wr_q <= op_write_i;
          addr_q  <= addr_i;
          left_q  <= count_i;
          err_q   <= 1'b0;
          if (count_i == '0) begin
            state_q <= ST_DONE;
          end else begin
            state_q    <= ST_FRAME;
            bits_q     <= BIT_W'(CMD_W);
            rd_frame_q <= !op_write_i;
            nxt_q      <= NX_WGET;
          end
        end
        ST_FRAME: if (eng_done) begin
          bits_q <= bits_q - BIT_W'(1);
          if (bits_q == BIT_W'(1)) begin
            if (rd_frame_q) begin
              state_q <= ST_RDIN;
              bits_q  <= BIT_W'(WORD_W + 1);   // dummy zero plus word
            end else begin
              state_q <= ST_GAP;
              gap_q   <= GAP_W'(CS_GAP_CYC - 1);
            end
          end
        end
        ST_RDIN: if (eng_done) begin
          cap_q  <= {cap_q[WORD_W-2:0], eng_bit};
          bits_q <= bits_q - BIT_W'(1);
          if (bits_q == BIT_W'(1)) begin
            rdata_q  <= {cap_q[WORD_W-2:0], eng_bit};
            rvalid_q <= 1'b1;
            addr_q   <= addr_q + ADDR_W'(1);
            left_q   <= left_q - CNT_W'(1);
            state_q  <= ST_GAP;
            gap_q    <= GAP_W'(CS_GAP_CYC - 1);
            nxt_q    <= (left_q == CNT_W'(1)) ? NX_DONE : NX_READ;
          end
        end
        ST_GAP: begin
          if (gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
          end else begin
            unique case (nxt_q)
              NX_WGET: state_q <= ST_WGET;
              NX_POLL: begin
                state_q <= ST_POLL;
                poll_q  <= '0;
              end
              NX_READ: begin
                state_q    <= ST_FRAME;
                bits_q     <= BIT_W'(CMD_W);
                rd_frame_q <= 1'b1;
              end
              NX_EWDS: begin
                state_q    <= ST_FRAME;
                bits_q     <= BIT_W'(CMD_W);
                rd_frame_q <= 1'b0;
                nxt_q      <= NX_DONE;
              end
              default: state_q <= ST_DONE;
            endcase
          end
        end
        ST_WGET: if (wvalid_i) begin
          state_q    <= ST_FRAME;
          bits_q     <= BIT_W'(FRAME_W);
          rd_frame_q <= 1'b0;
          nxt_q      <= NX_POLL;
        end
        ST_POLL: if (eng_done) begin
          if (eng_bit) begin
            addr_q  <= addr_q + ADDR_W'(1);
            left_q  <= left_q - CNT_W'(1);
            state_q <= ST_GAP;
            gap_q   <= GAP_W'(CS_GAP_CYC - 1);
            nxt_q   <= (left_q == CNT_W'(1)) ? NX_EWDS : NX_WGET;
          end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
            err_q   <= 1'b1;
            state_q <= ST_GAP;
            gap_q   <= GAP_W'(CS_GAP_CYC - 1);
            nxt_q   <= NX_EWDS;
          end else begin
            poll_q <= poll_q + POLL_W'(1);
          end
        end
        default: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  ee_bit_engine #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) u_bit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (eng_req),
    .di_i  (di_i),
    .idle_o(eng_idle),
    .sclk_o(sclk_o),
    .done_o(eng_done),
    .bit_o (eng_bit)
  );

  ee_frame_shift #(.W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld_en),
    .load_val_i(ld_val),
    .shift_i   (sh_en),
    .msb_o     (do_o)
  );

  // R7
  sclk_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> cs_o);
  // R8
  do_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(do_o));
  // R2
  rvalid_rd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !op_wr_q);
  // R9
  err_wr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> op_wr_q);
  // R5
  wready_cs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> !cs_o);
  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(op_wr_q));
endmodule

// File: tb/eeprom_serial_master_bench.sv
module eeprom_serial_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int LOWC  = 2;
  localparam int HIGHC = 3;
  localparam int GAPC  = 4;
  localparam int PMAX  = 64;
  localparam int BUSY_BITS = 5;
  localparam int NWORD = 1 << AW;
  localparam int NV = 8;
  // {write, addr[7:0], count[7:0]}
  localparam logic [16:0] VECS [0:NV-1] = '{
    {1'b0, 8'd0,  8'd3}, {1'b1, 8'd5,  8'd2}, {1'b0, 8'd4,  8'd4}, {1'b0, 8'd62, 8'd2},
    {1'b1, 8'd63, 8'd1}, {1'b0, 8'd63, 8'd1}, {1'b1, 8'd20, 8'd3}, {1'b0, 8'd19, 8'd5}
  };

  logic clk, rst_ni;
  logic start_i, op_write_i, wvalid_i;
  logic [AW-1:0] addr_i;
  logic [AW:0] count_i;
  logic [15:0] wdata_i, rdata_o;
  logic wready_o, rvalid_o, busy_o, done_o, err_o, cs_o, sclk_o, do_o;
  logic dev_do;

  int n_chk, n_fail;

  eeprom_serial_master #(
    .ADDR_W(AW), .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .CS_GAP_CYC(GAPC), .POLL_MAX(PMAX)
  ) u_eeprom_serial_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_write_i(op_write_i),
    .addr_i(addr_i), .count_i(count_i), .wdata_i(wdata_i), .wvalid_i(wvalid_i),
    .wready_o(wready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .cs_o(cs_o), .sclk_o(sclk_o), .do_o(do_o),
    .di_i(dev_do)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wpat(int a);
    return 16'(a * 16'h0107) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] ipat(int a);
    return 16'(a * 16'h0203) ^ 16'h5A0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [15:0] dev_mem [0:NWORD-1];
  logic [15:0] exp_mem [0:NWORD-1];
  logic [31:0] dev_sh;
  logic [16:0] dev_out;
  logic [AW-1:0] dev_a;
  logic [1:0] dev_op;
  int dev_bits, dev_busy;
  bit dev_rd, dev_wen, dev_wpend, dev_stuck;
  int n_ewen, n_ewds, n_bad, n_wr;

  always @(posedge sclk_o or negedge cs_o) begin
    if (!cs_o) begin
      if (dev_wpend) begin
        dev_busy  = dev_stuck ? (1 << 30) : BUSY_BITS;
        dev_wpend = 0;
      end else if (dev_stuck) begin
        dev_busy = 0;
      end
      dev_bits = 0; dev_sh = '0; dev_rd = 0; dev_do = 1'b0;
    end else if (dev_rd) begin
      dev_do  = dev_out[16];
      dev_out = {dev_out[15:0], 1'b0};
    end else if (dev_busy > 0) begin
      dev_busy = dev_busy - 1;
      dev_do   = (dev_busy == 0);
    end else if (dev_bits != 0 || do_o) begin
      dev_sh   = {dev_sh[30:0], do_o};
      dev_bits = dev_bits + 1;
      if (dev_bits == 3 + AW) begin
        dev_op = dev_sh[AW+1:AW];
        dev_a  = dev_sh[AW-1:0];
        if (dev_op == 2'b10) begin
          dev_rd = 1; dev_out = {1'b0, dev_mem[dev_a]};
        end else if (dev_op == 2'b00) begin
          if (dev_a == {2'b11, {(AW-2){1'b0}}}) begin dev_wen = 1; n_ewen++; end
          else if (dev_a == '0) begin dev_wen = 0; n_ewds++; end
          else n_bad++;
        end else if (dev_op == 2'b11) n_bad++;
      end
      if (dev_bits == 19 + AW && dev_sh[AW+17:AW+16] == 2'b01) begin
        dev_a = dev_sh[AW+15:16];
        if (dev_wen) begin
          dev_mem[dev_a] = dev_sh[15:0]; dev_wpend = 1; n_wr++;
        end else n_bad++;
      end
    end
  end

  // ---------------- timing monitor ----------------
  int hi_run, lo_run, cs_lo, min_hi, max_hi, min_lo, min_gap, cs_rises, sclk_viol;
  bit seen_cs;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!cs_o && sclk_o) sclk_viol++;
      if (sclk_o) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run < min_hi) min_hi = hi_run;
        if (hi_run > max_hi) max_hi = hi_run;
        hi_run = 0;
      end
      if (cs_o && !sclk_o) lo_run++;
      else if (sclk_o && lo_run != 0) begin
        if (lo_run < min_lo) min_lo = lo_run;
        lo_run = 0;
      end else if (!cs_o) lo_run = 0;
      if (!cs_o) cs_lo++;
      else begin
        if (cs_lo != 0) begin
          cs_rises++;
          if (seen_cs && cs_lo < min_gap) min_gap = cs_lo;
        end
        seen_cs = 1; cs_lo = 0;
      end
    end
  end

  // ---------------- host burst driver ----------------
  task automatic run_burst(input bit wr, input int a, input int n, input int poke_at,
                           output int got_r, output int got_w, output bit saw_done,
                           output bit err_at_done);
    int cyc, limit;
    bit took;
    got_r = 0; got_w = 0; saw_done = 0; err_at_done = 0; took = 0; cyc = 0;
    limit = 700 * (n + 2);
    @(negedge clk);
    start_i = 1'b1; op_write_i = wr; addr_i = AW'(a); count_i = (AW+1)'(n);
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      if (took) got_w++;
      if (cyc == poke_at) begin
        start_i = 1'b1; op_write_i = ~wr; addr_i = '0; count_i = 7'd5;
      end else if (cyc == poke_at + 1) begin
        start_i = 1'b0; op_write_i = wr;
      end
      wvalid_i = wr;
      wdata_i  = wpat((a + got_w) % NWORD);
      took = wready_o && wvalid_i;
      if (took) begin
        exp_mem[(a + got_w) % NWORD] = wdata_i;
        // R5: next word only requested once the device is idle again
        chk(dev_busy == 0, "R5", "word requested while device busy", dev_busy, 0);
      end
      if (rvalid_o) begin
        // R2 / R6: dummy bit dropped, consecutive addresses
        chk(rdata_o == exp_mem[(a + got_r) % NWORD], "R2", "read word",
            rdata_o, exp_mem[(a + got_r) % NWORD]);
        got_r++;
      end
      if (done_o) begin
        saw_done = 1; err_at_done = err_o;
        break;
      end
      cyc++;
      if (cyc > limit) break;
      @(negedge clk);
    end
    wvalid_i = 1'b0;
    start_i  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int gr, gw, ew0, ewd0, wr0, rises0;
    bit sd, ed;
    n_chk = 0; n_fail = 0;
    hi_run = 0; lo_run = 0; cs_lo = 0; min_hi = 1 << 20; max_hi = 0; min_lo = 1 << 20;
    min_gap = 1 << 20; cs_rises = 0; sclk_viol = 0; seen_cs = 0;
    dev_bits = 0; dev_busy = 0; dev_rd = 0; dev_wen = 0; dev_wpend = 0; dev_stuck = 0;
    dev_sh = '0; dev_out = '0; dev_do = 1'b0; dev_a = '0; dev_op = '0;
    n_ewen = 0; n_ewds = 0; n_bad = 0; n_wr = 0;
    for (int i = 0; i < NWORD; i++) begin
      dev_mem[i] = ipat(i); exp_mem[i] = ipat(i);
    end
    rst_ni = 1'b0; start_i = 1'b0; op_write_i = 1'b0; addr_i = '0; count_i = '0;
    wdata_i = '0; wvalid_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({cs_o, sclk_o, do_o, busy_o, done_o, err_o, wready_o, rvalid_o} == 8'h00,
        "R10", "outputs in reset", {cs_o, sclk_o, do_o, busy_o, done_o, err_o, wready_o, rvalid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({cs_o, sclk_o, do_o, busy_o, done_o, err_o, wready_o, rvalid_o} == 8'h00,
        "R10", "outputs after reset", {cs_o, sclk_o, do_o, busy_o, done_o, err_o, wready_o, rvalid_o}, 0);

    for (int v = 0; v < NV; v++) begin
      run_burst(VECS[v][16], int'(VECS[v][15:8]), int'(VECS[v][7:0]), -10, gr, gw, sd, ed);
      chk(sd, "R6", "burst completed", sd, 1);
      chk((VECS[v][16] ? gw : gr) == int'(VECS[v][7:0]), VECS[v][16] ? "R3" : "R6",
          "words transferred", VECS[v][16] ? gw : gr, VECS[v][7:0]);
      chk(!ed, "R9", "no error on healthy device", ed, 0);
    end
    // R4: each write burst wrapped in enable/disable
    chk(n_ewen == 3, "R4", "enable frames", n_ewen, 3);
    chk(n_ewds == 3, "R4", "disable frames", n_ewds, 3);
    chk(!dev_wen, "R4", "device left protected", dev_wen, 0);
    // R1: only legal frames seen, all writes landed
    chk(n_bad == 0, "R1", "illegal or unexpected frames", n_bad, 0);
    chk(n_wr == 6, "R3", "write frames accepted by device", n_wr, 6);

    // R6: zero count
    rises0 = cs_rises;
    run_burst(1'b0, 10, 0, -10, gr, gw, sd, ed);
    chk(sd && gr == 0, "R6", "zero count done without words", gr, 0);
    chk(cs_rises == rises0, "R6", "zero count chip select rises", cs_rises, rises0);

    // R11: start while busy ignored
    wr0 = n_wr;
    run_burst(1'b0, 8, 4, 40, gr, gw, sd, ed);
    chk(gr == 4 && gw == 0, "R11", "words with start during burst", gr, 4);
    chk(n_wr == wr0, "R11", "no write from ignored start", n_wr, wr0);

    // R9: device never ready
    ew0 = n_ewen; ewd0 = n_ewds;
    dev_stuck = 1;
    run_burst(1'b1, 30, 3, -10, gr, gw, sd, ed);
    chk(sd && ed, "R9", "error flagged at done", ed, 1);
    chk(gw == 1, "R9", "words taken before timeout", gw, 1);
    chk(n_ewds == ewd0 + 1 && n_ewen == ew0 + 1, "R9", "disable still sent", n_ewds, ewd0 + 1);
    chk(!dev_wen, "R9", "device protected after timeout", dev_wen, 0);
    @(negedge clk);
    chk(err_o, "R9", "error held after done", err_o, 1);
    dev_stuck = 0; dev_busy = 0;
    run_burst(1'b0, 30, 2, -10, gr, gw, sd, ed);
    chk(gr == 2 && !ed, "R9", "error cleared on next start", ed, 0);

    // R7 / R8: serial timing
    chk(sclk_viol == 0, "R7", "clock outside chip select", sclk_viol, 0);
    chk(min_gap >= GAPC, "R7", "chip select low gap", min_gap, GAPC);
    chk(min_hi == HIGHC && max_hi == HIGHC, "R8", "clock high length", min_hi, HIGHC);
    chk(min_lo >= LOWC, "R8", "clock low length", min_lo, LOWC);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule